// File: doc/BRIEF.md
# UART Modem Handshake and Flow Control Unit

This block looks after the four modem handshake inputs of a UART and its request-to-send output. The clear-to-send, data-set-ready, carrier-detect and ring inputs are all active low. Each one is synchronised into the core clock domain. The block reports whether each line is asserted. It also keeps one sticky change flag per line, which a status read clears, and it raises a modem status interrupt when a change flag is pending and the interrupt is enabled.

Request-to-send can be driven from a software bit. It can also be driven by the automatic flow controller, which compares the receive FIFO fill level against a trigger threshold. In automatic mode, clear-to-send also gates the start of each outgoing character. The transmitter raises a start request between characters, so a character already on the line always finishes. In this mode, clear-to-send changes are still recorded but no longer raise the interrupt. One enable bit turns on automatic mode. The software request-to-send bit then chooses between clear-to-send gating alone and gating plus automatic request-to-send.

Top module: `modem_flow_ctrl`

## Requirements
- R1: `mdm_stat_o[3:0]` gives the asserted state of the lines as bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 DCD. A bit reads 1 when its active-low input is low. A change on the input shows in the bit after exactly two rising clock edges.
- R2: `mdm_stat_o[7:4]` holds a sticky change flag per line, in the same order as R1. A flag sets one edge after its state bit changes. It stays set until an edge at which `stat_rd_i` is high clears it. A change detected in the same cycle as the read leaves the flag set.
- R3: With `auto_fc_i` low, `rts_n_o` equals the inverse of `rts_sw_i` one edge later. The FIFO level and threshold have no effect.
- R4: With `auto_fc_i` high and `rts_sw_i` low, only clear-to-send gating applies and `rts_n_o` is high one edge later.
- R5: With `auto_fc_i` and `rts_sw_i` both high, `rts_n_o` is high one edge after `rx_level_i >= rx_trig_i` and low one edge after `rx_level_i < rx_trig_i`.
- R6: With `auto_fc_i` high, `tx_start_o` follows `tx_req_i` only while the CTS state bit is 1. With `auto_fc_i` low, `tx_start_o` follows `tx_req_i` directly.
- R7: `msi_irq_o` is high only while `msi_en_i` is high and at least one change flag that counts toward the interrupt is set. The DSR, RI and DCD flags always count.
- R8: While `auto_fc_i` is high, the CTS change flag still sets but does not drive `msi_irq_o`. Once `auto_fc_i` is low again, a pending CTS flag does raise it.
- R9: After reset, all state and change bits are 0, `rts_n_o` is high and `msi_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_i | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_n_i | input | 1 | Ring line, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect line, active low, asynchronous |
| rts_sw_i | input | 1 | Software request-to-send bit |
| auto_fc_i | input | 1 | Automatic flow control enable |
| msi_en_i | input | 1 | Modem status interrupt enable |
| rx_level_i | input | LVL_W | Current receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO threshold for automatic request-to-send |
| stat_rd_i | input | 1 | Strobe: status register read this cycle |
| tx_req_i | input | 1 | Transmitter asks to start the next character |
| tx_start_o | output | 1 | Start permission granted to the transmitter |
| rts_n_o | output | 1 | Request-to-send line, active low |
| mdm_stat_o | output | 8 | Line states [3:0] and change flags [7:4] |
| msi_irq_o | output | 1 | Modem status interrupt |

## Verification
Several properties are checked on every cycle: request-to-send follows the software bit or the FIFO comparison one edge later, a start is never granted in automatic mode while clear-to-send is inactive, and the interrupt stays low while disabled. A change flag is also checked to stay set across every cycle with no read. The bench scenarios are the only evidence for the two-edge synchroniser latency and for the set-versus-clear race on a read. They also show the CTS flag being recorded without an interrupt in automatic mode, and the interrupt appearing once that mode ends.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  localparam int MDM_W   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  localparam int STAT_W  = 2 * MDM_W;
endpackage

// File: rtl/mfc_sync.sv
// Multi-stage synchroniser for the active-low modem lines plus one extra
// stage that holds the previous synchronised value for change detection.
module mfc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] pipe_q [DEPTH];
  logic [W-1:0] pipe_d [DEPTH];

  always_comb begin
    pipe_d[0] = async_i;
    for (int i = 1; i < DEPTH; i++) begin
      pipe_d[i] = pipe_q[i-1];
    end
  end

  // Idle level of an active-low line is high: reset to all ones so no
  // false change is seen when reset is released.
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q[g] <= '1;
        end else begin
          pipe_q[g] <= pipe_d[g];
        end
      end
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/mfc_delta.sv
// Sticky change flags, cleared by a status read; a change wins over a read.
module mfc_delta #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] change_i,
  input  logic         rd_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;
  logic [W-1:0] flag_d;
  logic         flag_en;

  assign flag_en = rd_i | (|change_i);

  always_comb begin
    flag_d = change_i | (flag_q & {W{~rd_i}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/mfc_rts.sv
// Registered request-to-send driver: software control or FIFO threshold.
module mfc_rts #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_fc_i,
  input  logic             rts_sw_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             rts_n_o
);
  logic rts_n_q;
  logic rts_n_d;
  logic auto_rts;
  logic fifo_high;

  assign auto_rts  = auto_fc_i & rts_sw_i;
  assign fifo_high = (level_i >= trig_i);

  always_comb begin
    if (auto_rts) begin
      rts_n_d = fifo_high;
    end else begin
      rts_n_d = ~rts_sw_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_n_q <= 1'b1;
    end else if (rts_n_d != rts_n_q) begin
      rts_n_q <= rts_n_d;
    end
  end

  assign rts_n_o = rts_n_q;
endmodule

// File: rtl/modem_flow_ctrl.sv
module modem_flow_ctrl
  import mfc_pkg::*;
#(
  parameter int LVL_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  input  logic              ri_n_i,
  input  logic              dcd_n_i,
  input  logic              rts_sw_i,
  input  logic              auto_fc_i,
  input  logic              msi_en_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [LVL_W-1:0]  rx_trig_i,
  input  logic              stat_rd_i,
  input  logic              tx_req_i,
  output logic              tx_start_o,
  output logic              rts_n_o,
  output logic [STAT_W-1:0] mdm_stat_o,
  output logic              msi_irq_o
);
  logic [MDM_W-1:0] lines_n;
  logic [MDM_W-1:0] sync_n;
  logic [MDM_W-1:0] prev_n;
  logic [MDM_W-1:0] change;
  logic [MDM_W-1:0] state;
  logic [MDM_W-1:0] delta;
  logic [MDM_W-1:0] irq_mask;

  always_comb begin
    lines_n          = '1;
    lines_n[IDX_CTS] = cts_n_i;
    lines_n[IDX_DSR] = dsr_n_i;
    lines_n[IDX_RI]  = ri_n_i;
    lines_n[IDX_DCD] = dcd_n_i;
  end

  mfc_sync #(.W(MDM_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lines_n),
    .sync_o  (sync_n),
    .prev_o  (prev_n)
  );

  assign state  = ~sync_n;
  assign change = sync_n ^ prev_n;

  mfc_delta #(.W(MDM_W)) delta_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .change_i (change),
    .rd_i     (stat_rd_i),
    .flag_o   (delta)
  );

  mfc_rts #(.LVL_W(LVL_W)) rts_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_fc_i (auto_fc_i),
    .rts_sw_i  (rts_sw_i),
    .level_i   (rx_level_i),
    .trig_i    (rx_trig_i),
    .rts_n_o   (rts_n_o)
  );

  // In automatic mode clear-to-send drives the transmitter, not the interrupt.
  always_comb begin
    irq_mask          = '1;
    irq_mask[IDX_CTS] = ~auto_fc_i;
  end

  assign msi_irq_o  = msi_en_i & (|(delta & irq_mask));
  assign tx_start_o = tx_req_i & (~auto_fc_i | state[IDX_CTS]);
  assign mdm_stat_o = {delta, state};
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rts_sw_i,
  input logic             auto_fc_i,
  input logic             msi_en_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] rx_trig_i,
  input logic             stat_rd_i,
  input logic             tx_start_o,
  input logic             rts_n_o,
  input logic [7:0]       mdm_stat_o,
  input logic             msi_irq_o
);
  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_fc_i |=> (rts_n_o == !$past(rts_sw_i))); // R3

  AST_RTS_AUTO_CTS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fc_i && !rts_sw_i) |=> rts_n_o); // R4

  AST_RTS_FIFO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fc_i && rts_sw_i && (rx_level_i >= rx_trig_i)) |=> rts_n_o); // R5

  AST_RTS_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fc_i && rts_sw_i && (rx_level_i < rx_trig_i)) |=> !rts_n_o); // R5

  AST_TX_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_fc_i && !mdm_stat_o[0]) |-> !tx_start_o); // R6

  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en_i |-> !msi_irq_o); // R7

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_stat_o[5] && !stat_rd_i) |=> mdm_stat_o[5]); // R2
endmodule

bind modem_flow_ctrl mfc_checker #(.LVL_W(LVL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rts_sw_i   (rts_sw_i),
  .auto_fc_i  (auto_fc_i),
  .msi_en_i   (msi_en_i),
  .rx_level_i (rx_level_i),
  .rx_trig_i  (rx_trig_i),
  .stat_rd_i  (stat_rd_i),
  .tx_start_o (tx_start_o),
  .rts_n_o    (rts_n_o),
  .mdm_stat_o (mdm_stat_o),
  .msi_irq_o  (msi_irq_o)
);

// File: tb/modem_flow_ctrl_tb_top.sv
module modem_flow_ctrl_tb_top;
  localparam int LVL_W = 5;
  localparam int NVEC  = 8;

  logic             clk;
  logic             rst_n;
  logic             cts_n, dsr_n, ri_n, dcd_n;
  logic             rts_sw, auto_fc, msi_en;
  logic [LVL_W-1:0] level, trig;
  logic             stat_rd, tx_req;
  logic             tx_start, rts_n, irq;
  logic [7:0]       stat;

  int checks = 0;
  int fails  = 0;
  bit timeout = 0;

  modem_flow_ctrl #(.LVL_W(LVL_W)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .cts_n_i (cts_n), .dsr_n_i (dsr_n), .ri_n_i (ri_n), .dcd_n_i (dcd_n),
    .rts_sw_i (rts_sw), .auto_fc_i (auto_fc), .msi_en_i (msi_en),
    .rx_level_i (level), .rx_trig_i (trig), .stat_rd_i (stat_rd),
    .tx_req_i (tx_req), .tx_start_o (tx_start), .rts_n_o (rts_n),
    .mdm_stat_o (stat), .msi_irq_o (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {auto, rts_sw, cts_n, req, level[4:0], trig[4:0], exp_rts_n, exp_tx}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 5'd0,  5'd8, 1'b1, 1'b1}, // R3 R6
    {1'b0, 1'b1, 1'b1, 1'b1, 5'd20, 5'd8, 1'b0, 1'b1}, // R3 level ignored
    {1'b1, 1'b0, 1'b0, 1'b1, 5'd20, 5'd8, 1'b1, 1'b1}, // R4
    {1'b1, 1'b0, 1'b1, 1'b1, 5'd0,  5'd8, 1'b1, 1'b0}, // R4 R6 blocked
    {1'b1, 1'b1, 1'b0, 1'b1, 5'd7,  5'd8, 1'b0, 1'b1}, // R5 below
    {1'b1, 1'b1, 1'b0, 1'b1, 5'd8,  5'd8, 1'b1, 1'b1}, // R5 equal
    {1'b1, 1'b1, 1'b1, 1'b0, 5'd9,  5'd8, 1'b1, 1'b0}, // R5 R6
    {1'b1, 1'b1, 1'b0, 1'b0, 5'd3,  5'd8, 1'b0, 1'b0}  // R5 R6 no request
  };

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
  endtask

  task automatic run_main();
    // reset state (R9)
    chk("R9 state", stat, 8'h00);
    chk("R9 rts_n", {7'd0, rts_n}, 8'h01);
    chk("R9 irq", {7'd0, irq}, 8'h00);
    chk("R9 tx", {7'd0, tx_start}, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      {auto_fc, rts_sw, cts_n, tx_req, level, trig} = VEC[v][15:2];
      step(3);
      chk("R3/R4/R5 rts_n", {7'd0, rts_n}, {7'd0, VEC[v][1]});
      chk("R6 tx_start", {7'd0, tx_start}, {7'd0, VEC[v][0]});
    end

    // idle lines, manual mode, clear deltas
    auto_fc = 1'b0; rts_sw = 1'b0; cts_n = 1'b1; tx_req = 1'b0;
    step(4);
    read_status();
    chk("R2 cleared", stat, 8'h00);

    // R1 latency on DSR
    msi_en = 1'b1;
    dsr_n = 1'b0;
    step();
    chk("R1 one edge", stat, 8'h00);
    step();
    chk("R1 two edges", stat, 8'h02);
    step();
    chk("R2 flag set", stat, 8'h22);
    chk("R7 irq on DSR", {7'd0, irq}, 8'h01);
    msi_en = 1'b0;
    #1;
    chk("R7 irq disabled", {7'd0, irq}, 8'h00);
    msi_en = 1'b1;
    step(5);
    chk("R2 sticky", stat, 8'h22);
    read_status();
    chk("R2 read clears", stat, 8'h02);
    chk("R7 irq drops", {7'd0, irq}, 8'h00);

    // R2 change in same cycle as read: RI flag survives
    ri_n = 1'b0;
    step(2);
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    chk("R2 set beats read", stat, 8'h46);
    read_status();
    chk("R2 later read", stat, 8'h06);

    // DCD change also sets flag and irq
    dcd_n = 1'b0;
    step(3);
    chk("R2 DCD flag", stat, 8'h8E);
    chk("R7 irq on DCD", {7'd0, irq}, 8'h01);
    read_status();

    // R8 CTS change in automatic mode
    auto_fc = 1'b1;
    cts_n = 1'b0;
    step(3);
    chk("R8 cts flag recorded", stat, 8'h1F);
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
    auto_fc = 1'b0;
    #1;
    chk("R8 irq after auto off", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0;
    cts_n = 1'b1; dsr_n = 1'b1; ri_n = 1'b1; dcd_n = 1'b1;
    rts_sw = 1'b0; auto_fc = 1'b0; msi_en = 1'b0;
    level = '0; trig = '0; stat_rd = 1'b0; tx_req = 1'b0;
    step(3);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    fork
      run_main();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule